// File: doc/BRIEF.md
# Carry-Chained Macro ALU

This block is the arithmetic and logic unit that a macro sequencer uses for register-to-register instructions. Two operands and a four-bit operation selector go in. The result and the carry value that the operation would leave behind come out combinationally in the same cycle. A single carry flip-flop inside the block holds the carry flag between instructions. It loads the proposed value only on a clock edge where the sequencer asserts the carry write enable, which it does for an ALU instruction that actually executes.

The four arithmetic operations all share one adder. For the two subtracting operations, the carry flag means that no borrow occurred. Subtract-with-borrow therefore takes away one extra unit only when the flag is clear. The logic operations and any unrecognised selector pass the stored carry through unchanged. An unrecognised selector also forces the result to zero and raises an illegal-operation flag.

Top module: `macro_alu`

## Requirements
- R1: Selector 0 (add) gives result = (a + b) mod 2^WIDTH, and carry_next is 1 exactly when a + b is at least 2^WIDTH.
- R2: Selector 1 (add with carry) gives result = (a + b + carry_q) mod 2^WIDTH, and carry_next is 1 exactly when that sum is at least 2^WIDTH.
- R3: Selector 2 (subtract) gives result = (a - b) mod 2^WIDTH, and carry_next is 1 exactly when a >= b as unsigned numbers.
- R4: Selector 3 (subtract with borrow) gives result = (a - b - 1) mod 2^WIDTH when carry_q is 0 and (a - b) mod 2^WIDTH when carry_q is 1. carry_next is 1 exactly when the true difference is not negative.
- R5: Selectors 8, 9, 10, 11 and 12 give a ^ b, a | b, a & b, a & ~b and ~(a & b) respectively.
- R6: For selectors 8 to 12, carry_next equals carry_q.
- R7: Any selector other than 0-3 and 8-12 gives result 0, illegal_op 1 and carry_next equal to carry_q. The legal selectors give illegal_op 0.
- R8: carry_q takes the value of carry_next at a rising clock edge where carry_we is 1, and keeps its value at an edge where carry_we is 0.
- R9: While rst_n is low, carry_q is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the carry flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation selector |
| carry_we | input | 1 | Load enable for the carry flag |
| result | output | WIDTH | Operation result |
| carry_next | output | 1 | Carry the current operation would store |
| carry_q | output | 1 | Stored carry flag |
| illegal_op | output | 1 | Selector is not a defined operation |

## Verification
The bench uses a four-bit instance and applies every selector value with every operand pair, once with the stored carry clear and once with it set. The carry-set and carry-clear sweeps tell the two add variants apart and the two subtract variants apart. The sweeps also show whether a logic or illegal code disturbs the flag. Operand pairs with a equal to b, a just above b, and a just below b separate a borrow from no borrow. Operand pairs whose sum crosses 2^WIDTH, including all-ones plus carry, catch an off-by-one in carry generation. The write enable alternates across the vectors, so a load and a hold of the flag are both observed after each operation.

// File: rtl/macro_alu.sv
module macro_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       op_sel,
  input  logic             carry_we,
  output logic [WIDTH-1:0] result,
  output logic             carry_next,
  output logic             carry_q,
  output logic             illegal_op
);

  localparam logic [3:0] SEL_ADD  = 4'd0;
  localparam logic [3:0] SEL_ADDC = 4'd1;
  localparam logic [3:0] SEL_SUB  = 4'd2;
  localparam logic [3:0] SEL_SUBB = 4'd3;
  localparam logic [3:0] SEL_XOR  = 4'd8;
  localparam logic [3:0] SEL_OR   = 4'd9;
  localparam logic [3:0] SEL_AND  = 4'd10;
  localparam logic [3:0] SEL_ANDN = 4'd11;
  localparam logic [3:0] SEL_NAND = 4'd12;

  // One adder serves all four arithmetic ops; subtraction adds the complement.
  wire              is_arith = (op_sel[3:2] == 2'b00);
  wire              is_sub   = op_sel[1];
  wire              use_cf   = op_sel[0];
  wire [WIDTH-1:0]  b_eff    = is_sub ? ~op_b : op_b;
  wire              cin      = use_cf ? carry_q : is_sub;
  wire [WIDTH:0]    sum      = {1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    result     = '0;
    carry_next = carry_q;
    illegal_op = 1'b0;
    case (op_sel)
      SEL_ADD, SEL_ADDC, SEL_SUB, SEL_SUBB: begin
        result     = sum[WIDTH-1:0];
        carry_next = sum[WIDTH];
      end
      SEL_XOR:  result = op_a ^ op_b;
      SEL_OR:   result = op_a | op_b;
      SEL_AND:  result = op_a & op_b;
      SEL_ANDN: result = op_a & ~op_b;
      SEL_NAND: result = ~(op_a & op_b);
      default:  illegal_op = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        carry_q <= 1'b0;
    else if (carry_we) carry_q <= carry_next;
  end

  p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == SEL_ADD) |-> (carry_next == (result < op_a)));

  p_sub_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == SEL_SUB) |-> (carry_next == (op_a >= op_b)));

  p_logic_keeps_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= SEL_XOR && op_sel <= SEL_NAND) |-> (carry_next == carry_q));

  p_illegal_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (result == '0 && carry_next == carry_q));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    carry_we |=> (carry_q == $past(carry_next)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_we |=> (carry_q == $past(carry_q)));

  always_comb begin
    if (rst_n !== 1'b0 && is_arith)
      a_arith_legal_r7: assert (illegal_op == 1'b0);
  end

endmodule

// File: tb/sim_macro_alu.sv
module sim_macro_alu;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] a, b;
  logic [3:0]   op;
  logic         we;
  logic [W-1:0] res;
  logic         cn, cq, ill;

  macro_alu #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .op_sel(op),
    .carry_we(we), .result(res), .carry_next(cn), .carry_q(cq),
    .illegal_op(ill)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic set_carry(int c);
    @(negedge clk);
    op = 4'd0;
    a  = c ? W'(M) : '0;
    b  = c ? W'(1) : '0;
    we = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; a = '0; b = '0; op = '0; we = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 carry during reset", int'(cq), 0);
    a = W'(M); b = W'(1);
    @(negedge clk);
    chk("R9 carry held at 0 under reset with load", int'(cq), 0);
    rst_n = 1'b1;
    we = 1'b0;
    @(negedge clk);
    chk("R9 carry after reset release", int'(cq), 0);

    for (int o = 0; o < 16; o++) begin
      for (int c = 0; c < 2; c++) begin
        for (int ai = 0; ai <= M; ai++) begin
          for (int bi = 0; bi <= M; bi++) begin
            int    er, ec, ei, s;
            string tg;
            logic  wv;
            set_carry(c);
            @(negedge clk);
            wv = 1'(ai ^ bi ^ o);
            op = 4'(o); a = W'(ai); b = W'(bi); we = wv;
            ei = 0; ec = c; er = 0;
            case (o)
              0:  begin tg = "R1"; s = ai + bi;     er = s & M; ec = (s > M); end
              1:  begin tg = "R2"; s = ai + bi + c; er = s & M; ec = (s > M); end
              2:  begin tg = "R3"; s = ai - bi;     er = s & M; ec = (s >= 0); end
              3:  begin tg = "R4"; s = ai - bi - (c ? 0 : 1); er = s & M; ec = (s >= 0); end
              8:  begin tg = "R5 R6"; er = (ai ^ bi) & M; end
              9:  begin tg = "R5 R6"; er = (ai | bi) & M; end
              10: begin tg = "R5 R6"; er = (ai & bi) & M; end
              11: begin tg = "R5 R6"; er = (ai & ~bi) & M; end
              12: begin tg = "R5 R6"; er = ~(ai & bi) & M; end
              default: begin tg = "R7"; ei = 1; end
            endcase
            #1;
            chk($sformatf("%s result op=%0d a=%0d b=%0d c=%0d", tg, o, ai, bi, c), int'(res), er);
            chk($sformatf("%s carry_next op=%0d a=%0d b=%0d c=%0d", tg, o, ai, bi, c), int'(cn), ec);
            chk($sformatf("R7 illegal op=%0d", o), int'(ill), ei);
            @(negedge clk);
            chk($sformatf("R8 carry_q we=%0d op=%0d a=%0d b=%0d c=%0d", wv, o, ai, bi, c),
                int'(cq), wv ? ec : c);
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule